// File: doc/BRIEF.md
# Edge-Latched Bytewide Memory Emulator

This block is a clocked stand-in for the device side of an asynchronous bytewide memory whose every access has to start with a falling edge of chip enable. The three active-low strobes are chip enable, write enable and output enable. The block oversamples them with a fast system clock through a two-stage synchronizer and finds their edges. It also keeps a byte-wide storage array inside. The address and write data pass through the same number of register stages as the strobes, so each one lines up with the strobe sample taken at the same moment.

The block latches the address when chip enable falls and ignores later address changes. The level of write enable at that edge decides whether the cycle starts as a write or as a read. A read cycle turns into a write when write enable falls later. Read data is offered only after a parameterised access time has passed, and only while output enable is low. A write takes the data that is present at the first rising edge of chip enable or write enable. A cycle that starts before chip enable has been high for the precharge time is flagged and ignored. All thresholds are counts of system-clock cycles.

The block fits an FPGA stand-in for the memory or a bus-side checker of a memory controller. The default array is 1024 bytes. Setting `ADDR_W` to 15 gives the full 32768-byte organisation.

Top module: `edge_latched_mem_emu`

## Requirements
- R1: The address is taken from the sample in which synchronized chip enable is first seen low. Address changes after that sample have no effect until chip enable has risen and fallen again.
- R2: If write enable is low in the sample where chip enable is first seen low, the cycle is a write. `rdata_oe` stays 0 for the whole cycle, whatever the level of output enable.
- R3: If write enable is high at the chip-enable fall, the cycle is a read. The read drives normally until write enable falls. `rdata_oe` then goes to 0, and the cycle becomes a write.
- R4: `rdata_oe` is 1 only while output enable is low and ACCESS_CYC cycles have passed since the cycle began. With pins changed between clock edges, the first possible high sample follows the (ACCESS_CYC+SYNC_STAGES+1)-th rising edge after chip enable falls. Output enable lowered later takes effect after SYNC_STAGES edges.
- R5: A write stores the write data present at the first rising edge of write enable or chip enable, at the latched address. A later read returns that byte.
- R6: A chip-enable fall seen after fewer than PRECHG_CYC consecutive high samples is a violation. `timing_viol` is 1 from SYNC_STAGES+1 edges after the pin fall until chip enable rises again. The cycle neither writes nor drives. A fall after exactly PRECHG_CYC high samples is accepted.
- R7: `rdata_oe` falls within SYNC_STAGES rising edges after output enable rises, chip enable rises or write enable falls.
- R8: After reset, `rdata_oe` and `timing_viol` are 0. `rdata` is 0 whenever `rdata_oe` is 0.
- R9: After a write ends on a write-enable rise with chip enable still low, further write-enable pulses in the same cycle neither store data nor enable the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_en_n | input | 1 | Active-low chip enable strobe |
| wr_en_n | input | 1 | Active-low write enable strobe |
| out_en_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data from the bus |
| rdata | output | DATA_W | Read data, zero when not driven |
| rdata_oe | output | 1 | Data-drive enable for the bus |
| timing_viol | output | 1 | Precharge violation flag for the current cycle |

## Verification
The case that is hardest to reach from the ports is a cycle started too soon after the previous one. The stimulus has to end a cycle and then bring chip enable low again after a number of high samples exactly one short of PRECHG_CYC, or exactly equal to it. The bench does this by controlling the hold time of each cycle end to the clock cycle. It then reads the target byte back to show that the violating write left it unchanged. The second delicate case is a write cycle that ends on write enable while chip enable stays low, followed by a second write-enable pulse. The bench steers this pulse onto different data and proves through a later read that the pulse was ignored.

// File: rtl/elm_pkg.sv
package elm_pkg;

   typedef enum logic [2:0] {
      CY_IDLE,
      CY_READ,
      CY_WRITE,
      CY_HOLD,
      CY_VOID
   } cyc_state_t;

endpackage

// File: rtl/elm_sync.sv
module elm_sync #(
   parameter int              W       = 1,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stg
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/elm_store.sv
module elm_store #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) cells[wr_addr] <= wr_data;
      rd_data <= cells[rd_addr];
   end

endmodule

// File: rtl/elm_cycle_ctrl.sv
module elm_cycle_ctrl
   import elm_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int ACCESS_CYC = 7,
   parameter int PRECHG_CYC = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_s,
   input  logic              we_s,
   input  logic              oe_s,
   input  logic [ADDR_W-1:0] addr_s,
   output logic [ADDR_W-1:0] lat_addr,
   output logic              commit,
   output logic              drive,
   output logic              viol
);

   localparam int ACW = $clog2(ACCESS_CYC + 1);
   localparam int PCW = $clog2(PRECHG_CYC + 1);
   localparam logic [ACW-1:0] ACC_LIM = ACW'(ACCESS_CYC);
   localparam logic [PCW-1:0] PRE_LIM = PCW'(PRECHG_CYC);

   cyc_state_t     st, st_nx;
   logic           ce_prev;
   logic           fall;
   logic           short_pre;
   logic [PCW-1:0] hi_cnt;
   logic [ACW-1:0] acc_cnt;

   assign fall      = ce_prev & ~ce_s;
   assign short_pre = (hi_cnt < PRE_LIM);

   always_comb begin
      st_nx = st;
      unique case (st)
         CY_IDLE: begin
            if (fall) begin
               if (short_pre)  st_nx = CY_VOID;
               else if (!we_s) st_nx = CY_WRITE;
               else            st_nx = CY_READ;
            end
         end
         CY_READ: begin
            if (ce_s)       st_nx = CY_IDLE;
            else if (!we_s) st_nx = CY_WRITE;
         end
         CY_WRITE: begin
            if (ce_s)       st_nx = CY_IDLE;
            else if (we_s)  st_nx = CY_HOLD;
         end
         CY_HOLD, CY_VOID: begin
            if (ce_s)       st_nx = CY_IDLE;
         end
         default: st_nx = CY_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= CY_IDLE;
         ce_prev  <= 1'b1;
         hi_cnt   <= PRE_LIM;
         acc_cnt  <= '0;
         lat_addr <= '0;
      end else begin
         st      <= st_nx;
         ce_prev <= ce_s;
         if (!ce_s)                  hi_cnt <= '0;
         else if (hi_cnt != PRE_LIM) hi_cnt <= hi_cnt + 1'b1;
         if (st == CY_IDLE)          acc_cnt <= '0;
         else if (st == CY_READ && acc_cnt != ACC_LIM)
                                     acc_cnt <= acc_cnt + 1'b1;
         if (st == CY_IDLE && fall)  lat_addr <= addr_s;
      end
   end

   assign commit = (st == CY_WRITE) && (ce_s || we_s);
   assign drive  = (st == CY_READ) && (acc_cnt == ACC_LIM) &&
                   !oe_s && !ce_s && we_s;
   assign viol   = (st == CY_VOID);

endmodule

// File: rtl/edge_latched_mem_emu.sv
module edge_latched_mem_emu #(
   parameter int ADDR_W      = 10,
   parameter int DATA_W      = 8,
   parameter int ACCESS_CYC  = 7,
   parameter int PRECHG_CYC  = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chip_en_n,
   input  logic              wr_en_n,
   input  logic              out_en_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_oe,
   output logic              timing_viol
);

   localparam int PW = ADDR_W + DATA_W;

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= 16)
         else $error("ADDR_W out of range");
      assert (DATA_W >= 1)
         else $error("DATA_W must be positive");
      assert (ACCESS_CYC >= 2)
         else $error("ACCESS_CYC must cover the array read latency");
      assert (PRECHG_CYC >= 1)
         else $error("PRECHG_CYC must be positive");
      assert (SYNC_STAGES >= 2)
         else $error("SYNC_STAGES must be at least two");
   end

   logic [2:0]        ctl_sync;
   logic              ce_sync, we_sync, oe_sync;
   logic [PW-1:0]     pay_sync;
   logic [ADDR_W-1:0] addr_sync;
   logic [DATA_W-1:0] wd_sync;
   logic [ADDR_W-1:0] lat_addr;
   logic              wr_commit;
   logic              drive_ok;
   logic [DATA_W-1:0] arr_q;

   elm_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_ctl_sync (
      .clk(clk), .rst_n(rst_n),
      .d({chip_en_n, wr_en_n, out_en_n}), .q(ctl_sync)
   );

   elm_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pay_sync (
      .clk(clk), .rst_n(rst_n),
      .d({addr, wdata}), .q(pay_sync)
   );

   assign {ce_sync, we_sync, oe_sync} = ctl_sync;
   assign {addr_sync, wd_sync}        = pay_sync;

   elm_cycle_ctrl #(
      .ADDR_W(ADDR_W), .ACCESS_CYC(ACCESS_CYC), .PRECHG_CYC(PRECHG_CYC)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .ce_s(ce_sync), .we_s(we_sync), .oe_s(oe_sync),
      .addr_s(addr_sync),
      .lat_addr(lat_addr), .commit(wr_commit),
      .drive(drive_ok), .viol(timing_viol)
   );

   elm_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk(clk),
      .wr_en(wr_commit), .wr_addr(lat_addr), .wr_data(wd_sync),
      .rd_addr(lat_addr), .rd_data(arr_q)
   );

   assign rdata_oe = drive_ok;
   assign rdata    = drive_ok ? arr_q : '0;

endmodule

// File: rtl/edge_latched_mem_emu_chk.sv
module edge_latched_mem_emu_chk #(
   parameter int ADDR_W     = 10,
   parameter int ACCESS_CYC = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_s,
   input logic              we_s,
   input logic              oe_s,
   input logic              rdata_oe,
   input logic              timing_viol,
   input logic              commit,
   input logic [ADDR_W-1:0] lat_addr
);

   localparam int LW = $clog2(ACCESS_CYC + 2);
   localparam logic [LW-1:0] LOW_SAT = LW'(ACCESS_CYC + 1);

   logic [LW-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                low_cnt <= '0;
      else if (ce_s)             low_cnt <= '0;
      else if (low_cnt != LOW_SAT) low_cnt <= low_cnt + 1'b1;
   end

   // R1
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_s && $past(!ce_s)) |=> $stable(lat_addr));

   // R4
   no_early_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_oe |-> (low_cnt == LOW_SAT));

   // R4
   drive_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_oe |-> (!oe_s && we_s));

   // R5
   commit_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (ce_s || we_s));

   // R6
   viol_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timing_viol |-> (!rdata_oe && !commit));

   // R7
   ce_rise_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ce_s) |-> !rdata_oe);

   // R3
   we_fall_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(we_s) |-> !rdata_oe);

endmodule

bind edge_latched_mem_emu edge_latched_mem_emu_chk #(
   .ADDR_W(ADDR_W), .ACCESS_CYC(ACCESS_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .ce_s(ce_sync), .we_s(we_sync), .oe_s(oe_sync),
   .rdata_oe(rdata_oe), .timing_viol(timing_viol),
   .commit(wr_commit), .lat_addr(lat_addr)
);

// File: tb/edge_latched_mem_emu_bench.sv
module edge_latched_mem_emu_bench;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 10;
   localparam int DATA_W     = 8;
   localparam int ACCESS_CYC = 7;
   localparam int PRECHG_CYC = 6;
   localparam int SYNC       = 2;
   localparam int DEPTH      = 1 << ADDR_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              chip_en_n = 1'b1;
   logic              wr_en_n = 1'b1;
   logic              out_en_n = 1'b1;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] rdata;
   logic              rdata_oe;
   logic              timing_viol;

   int tests = 0;
   int fails = 0;
   int cyc   = 0;
   logic [DATA_W-1:0] model [DEPTH];

   edge_latched_mem_emu #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACCESS_CYC(ACCESS_CYC),
      .PRECHG_CYC(PRECHG_CYC), .SYNC_STAGES(SYNC)
   ) u_edge_latched_mem_emu (
      .clk(clk), .rst_n(rst_n),
      .chip_en_n(chip_en_n), .wr_en_n(wr_en_n), .out_en_n(out_en_n),
      .addr(addr), .wdata(wdata),
      .rdata(rdata), .rdata_oe(rdata_oe), .timing_viol(timing_viol)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         fails = fails + 1;
         $display("FAIL watchdog (all requirements): actual %0d cycles, expected fewer", cyc);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   // edges after a chip-enable pin fall before the first driven sample
   function automatic int drive_edge();
      return ACCESS_CYC + SYNC + 1;
   endfunction

   function automatic int hold_time();
      return PRECHG_CYC + SYNC;
   endfunction

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      tests = tests + 1;
      if (act !== exp) begin
         fails = fails + 1;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // read cycle, ending with chip enable high for hold samples
   task automatic rd_op(input logic [ADDR_W-1:0] a, input int hold);
      addr = a; wr_en_n = 1'b1; out_en_n = 1'b0; chip_en_n = 1'b0;
      tick(1);
      addr = ~a;   // R1: ignored after the latch
      tick(drive_edge() - 2);
      chk("R4 no early drive", rdata_oe, 1'b0);
      chk("R8 rdata zero when idle", rdata, '0);
      tick(1);
      chk("R4 drive after access time", rdata_oe, 1'b1);
      chk("R1 R5 read data", rdata, model[a]);
      chip_en_n = 1'b1;
      tick(SYNC - 1);
      chk("R7 still driven before ce sync", rdata_oe, 1'b1);
      tick(1);
      chk("R7 stop after ce rise", rdata_oe, 1'b0);
      out_en_n = 1'b1;
      tick(hold - SYNC);
   endtask

   // cycle that starts as a write: write enable low at the fall
   task automatic wr_ce(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                        input logic oe_val);
      addr = a; wdata = d; wr_en_n = 1'b0; out_en_n = oe_val; chip_en_n = 1'b0;
      tick(1);
      addr = ~a;
      for (int i = 0; i < drive_edge() + 2; i++) begin
         tick(1);
         if (i % 4 == 3) chk("R2 write cycle never drives", rdata_oe, 1'b0);
      end
      chip_en_n = 1'b1;
      tick(1);
      wr_en_n = 1'b1; out_en_n = 1'b1;
      tick(hold_time());
      model[a] = d;
   endtask

   // cycle that starts as a read and turns into a write
   task automatic wr_we(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                        input logic [DATA_W-1:0] d2);
      addr = a; wr_en_n = 1'b1; out_en_n = 1'b0; chip_en_n = 1'b0;
      tick(drive_edge());
      chk("R3 read phase drives", rdata_oe, 1'b1);
      wr_en_n = 1'b0; wdata = d;
      tick(SYNC - 1);
      chk("R3 drive until we sync", rdata_oe, 1'b1);
      tick(1);
      chk("R3 R7 stop after we fall", rdata_oe, 1'b0);
      tick(3);
      wr_en_n = 1'b1;
      tick(SYNC + 2);
      wdata = d2; wr_en_n = 1'b0;
      tick(3);
      chk("R9 no drive after we-ended write", rdata_oe, 1'b0);
      wr_en_n = 1'b1;
      tick(SYNC + 2);
      chk("R9 no drive after second we pulse", rdata_oe, 1'b0);
      chip_en_n = 1'b1; out_en_n = 1'b1;
      tick(hold_time());
      model[a] = d;
   endtask

   initial begin
      logic [ADDR_W-1:0] va;
      void'($urandom(32'h5EED_0042));
      tick(3);
      chk("R8 reset drive enable", rdata_oe, 1'b0);
      chk("R8 reset violation flag", timing_viol, 1'b0);
      chk("R8 reset data", rdata, '0);
      rst_n = 1'b1;
      tick(2);
      chk("R8 idle after reset", rdata_oe, 1'b0);

      // directed writes at boundary addresses, both write styles
      wr_ce(10'd0, 8'hA5, 1'b0);
      wr_ce(10'(DEPTH - 1), 8'h3C, 1'b1);
      wr_we(10'd17, 8'h81, 8'h7E);
      rd_op(10'd0, hold_time());
      rd_op(10'(DEPTH - 1), hold_time());
      rd_op(10'd17, hold_time());   // R9: second pulse data not stored

      // late output enable
      addr = 10'd0; wr_en_n = 1'b1; out_en_n = 1'b1; chip_en_n = 1'b0;
      tick(drive_edge() + 3);
      chk("R4 oe high holds drive off", rdata_oe, 1'b0);
      out_en_n = 1'b0;
      tick(SYNC - 1);
      chk("R4 oe not yet synchronized", rdata_oe, 1'b0);
      tick(1);
      chk("R4 late oe drives", rdata_oe, 1'b1);
      chk("R4 late oe data", rdata, model[0]);
      out_en_n = 1'b1;
      tick(SYNC);
      chk("R7 stop after oe rise", rdata_oe, 1'b0);
      chip_en_n = 1'b1;
      tick(hold_time());

      // precharge exactly at the limit is accepted
      rd_op(10'd17, PRECHG_CYC);
      chk("R6 exact precharge no flag", timing_viol, 1'b0);
      rd_op(10'd17, PRECHG_CYC - 1);

      // violating cycle: write with oe low after short precharge
      va = 10'd17;
      addr = va; wdata = 8'h5A; wr_en_n = 1'b0; out_en_n = 1'b0; chip_en_n = 1'b0;
      tick(SYNC);
      chk("R6 flag not before state update", timing_viol, 1'b0);
      tick(1);
      chk("R6 short precharge flagged", timing_viol, 1'b1);
      tick(drive_edge());
      chk("R6 violating cycle holds flag", timing_viol, 1'b1);
      chk("R6 violating cycle not driven", rdata_oe, 1'b0);
      chip_en_n = 1'b1;
      tick(1);
      wr_en_n = 1'b1; out_en_n = 1'b1;
      tick(hold_time());
      chk("R6 flag clears after ce rise", timing_viol, 1'b0);
      rd_op(va, hold_time());       // R6: byte unchanged

      // violating read with oe low
      rd_op(10'd0, PRECHG_CYC - 2);
      addr = 10'd0; wr_en_n = 1'b1; out_en_n = 1'b0; chip_en_n = 1'b0;
      tick(drive_edge() + 2);
      chk("R6 violating read not driven", rdata_oe, 1'b0);
      chk("R6 violating read flagged", timing_viol, 1'b1);
      chip_en_n = 1'b1; out_en_n = 1'b1;
      tick(hold_time());

      // constrained random traffic over a small address window
      for (int i = 0; i < 16; i++) wr_ce(10'(i), 8'($urandom), 1'($urandom));
      for (int i = 0; i < 40; i++) begin
         int op;
         logic [ADDR_W-1:0] ra;
         op = int'($urandom % 3);
         ra = 10'($urandom % 16);
         if (op == 0)      wr_ce(ra, 8'($urandom), 1'($urandom));
         else if (op == 1) wr_we(ra, 8'($urandom), 8'($urandom));
         else              rd_op(ra, hold_time() + int'($urandom % 3));
      end
      for (int i = 0; i < 16; i++) rd_op(10'(i), hold_time());

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule